// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block runs byte programming and erasure on four flash regions that share one byte store: a boot flash split into four banks, a microcontroller flash, and two small auxiliary sectors. Software controls it through one 8-bit control word. The word names a region, a kind of operation and a start bit. A separate 2-bit bank register chooses which quarter of the boot flash the address bits reach.

When a start is accepted, the sequencer takes a copy of the operation address and data. It then walks the target byte range one byte per cycle. After that it holds for a configurable settle count, so a mass erase that lasts hundreds of milliseconds on silicon takes only a few cycles in simulation. A busy flag covers the whole operation and a one-cycle done pulse marks its end. A start is refused with a one-cycle pulse when programming is locked, or when the region or operation code is unknown. All control and bank writes are dropped while an operation is pending or running.

The store is a behavioural byte array with a read port that has one cycle of latency. Erased bytes hold 0xFF. Programming can only clear bits.

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset, busy, done, refused, the control readback and the bank readback are all zero, and every byte of every region reads 0xFF.
- R2: The control word has three fields. Bits 7:5 are the operation: 001 program, 010 sector erase, 100 mass erase. Bit 4 is start. Bits 3:0 are the region: 0 boot, 1 microcontroller, 2 auxiliary 0, 3 auxiliary 1. The readback shows the written word for one cycle, and then bit 4 reads 0. A write with bit 4 clear starts nothing.
- R3: A program operation stores the old byte ANDed with the operation data, so programming never sets a bit.
- R4: A boot-flash program targets offset bank*BANK_BYTES + (address mod BANK_BYTES). The bank register keeps only the low 2 bits of a write.
- R5: Microcontroller and auxiliary program addresses wrap modulo the size of their region.
- R6: A sector erase sets to 0xFF the aligned sector that holds the addressed byte. On the boot flash this sector is BOOT_SECT bytes inside the selected bank. On the microcontroller flash it is MCU_SECT bytes. Bytes outside the sector keep their values.
- R7: A sector erase or a mass erase of an auxiliary region sets that whole region to 0xFF.
- R8: A mass erase sets the whole region to 0xFF, including all four boot banks, and leaves the other regions unchanged.
- R9: Busy rises one cycle after the start write. It stays high for a number of cycles equal to the bytes touched plus the settle count (PROG_CYC, SECT_CYC or MASS_CYC). A program operation touches 1 byte.
- R10: If programming was locked when the start was written, refused pulses one cycle after the write, busy stays low and no byte changes.
- R11: An unknown region code or operation code is refused in the same way as R10.
- R12: Control and bank writes that arrive while an operation is pending or busy are dropped, and the readbacks keep their values.
- R13: Done pulses for one cycle in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock | input | 1 | Programming enabled; sampled with the start write |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the bank register |
| reg_wdata | input | 8 | Register write data |
| op_addr | input | 16 | Operation address, captured with the start |
| op_data | input | 8 | Program data, captured with the start |
| rd_region | input | 4 | Read region code |
| rd_off | input | 16 | Read offset within the region (for boot, the absolute offset across banks) |
| rd_data | output | 8 | Read byte, one cycle after the address; 0 for an unknown region |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| refused | output | 1 | One-cycle refusal pulse |
| ctrl_rd | output | 8 | Control word readback |
| bank_rd | output | 2 | Bank register readback |

## Verification
Faults in the byte walk show up at the read port. A sector base computed wrongly, or a length that is off by one, leaves a byte that should be 0xFF with its old value, or clears a neighbour that should be untouched. The full-store scan after each operation exposes this within one scan. A settle counter that stops early or late changes the busy length by at least one cycle, and the bench counts that length exactly. If the lock or the decode is wrong, the refused pulse is missing or the store changes. A start latch that does not clear shows up one cycle later in the control readback.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int NUM_BANKS  = 4;
    localparam int BANK_SEL_W = 2;

    localparam logic [3:0] RGN_BOOT = 4'd0;
    localparam logic [3:0] RGN_MCU  = 4'd1;
    localparam logic [3:0] RGN_AUX0 = 4'd2;
    localparam logic [3:0] RGN_AUX1 = 4'd3;

    localparam logic [2:0] OPC_PROG = 3'b001;
    localparam logic [2:0] OPC_SECT = 3'b010;
    localparam logic [2:0] OPC_MASS = 3'b100;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_BANK = 1'b1;

    typedef enum logic [1:0] {
        JOB_PROG,
        JOB_SECT,
        JOB_MASS
    } job_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PROG,
        SQ_ERASE,
        SQ_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [2:0] op;
        logic       go;
        logic [3:0] region;
    } ctrl_t;

    function automatic logic op_known(input logic [2:0] op);
        return (op == OPC_PROG) || (op == OPC_SECT) || (op == OPC_MASS);
    endfunction

    function automatic job_e op_to_job(input logic [2:0] op);
        job_e j;
        case (op)
            OPC_SECT: j = JOB_SECT;
            OPC_MASS: j = JOB_MASS;
            default:  j = JOB_PROG;
        endcase
        return j;
    endfunction

    function automatic logic region_known(input logic [3:0] r);
        return r <= RGN_AUX1;
    endfunction

endpackage

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
    import flash_seq_pkg::*;
#(
    parameter int IAW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic                  reg_sel,
    input  logic [7:0]            reg_wdata,
    input  logic [IAW-1:0]        op_addr,
    input  logic [7:0]            op_data,
    input  logic                  unlock,
    input  logic                  busy_i,
    output ctrl_t                 ctrl_q,
    output logic                  start_q,
    output logic [BANK_SEL_W-1:0] bank_q,
    output logic [IAW-1:0]        addr_q,
    output logic [7:0]            data_q,
    output logic                  unlock_q
);

    logic accept;
    assign accept = reg_we && !busy_i && !start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            start_q  <= 1'b0;
            bank_q   <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            unlock_q <= 1'b0;
        end else begin
            start_q   <= 1'b0;
            ctrl_q.go <= 1'b0;
            if (accept && reg_sel == SEL_CTRL) begin
                ctrl_q  <= ctrl_t'(reg_wdata);
                start_q <= reg_wdata[4];
                if (reg_wdata[4]) begin
                    addr_q   <= op_addr;
                    data_q   <= op_data;
                    unlock_q <= unlock;
                end
            end
            if (accept && reg_sel == SEL_BANK) begin
                bank_q <= reg_wdata[BANK_SEL_W-1:0];
            end
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q); // R2

    AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_i && $past(busy_i)) |-> ($stable(ctrl_q) && $stable(bank_q))); // R12

endmodule

// File: rtl/flash_pe_map.sv
module flash_pe_map
    import flash_seq_pkg::*;
#(
    parameter int BANK_BYTES = 256,
    parameter int BOOT_SECT  = 64,
    parameter int MCU_BYTES  = 256,
    parameter int MCU_SECT   = 32,
    parameter int AUX0_BYTES = 64,
    parameter int AUX1_BYTES = 16,
    parameter int AW         = 11,
    parameter int IAW        = 16
) (
    input  logic [3:0]            region,
    input  job_e                  kind,
    input  logic [BANK_SEL_W-1:0] bank,
    input  logic [IAW-1:0]        addr,
    output logic                  region_ok,
    output logic [AW-1:0]         base,
    output logic [AW-1:0]         len
);

    localparam int BOOT_TOTAL = NUM_BANKS * BANK_BYTES;
    localparam int BANK_AW    = $clog2(BANK_BYTES);
    localparam int MCU_AW     = $clog2(MCU_BYTES);
    localparam int AUX0_AW    = $clog2(AUX0_BYTES);
    localparam int AUX1_AW    = $clog2(AUX1_BYTES);
    localparam int MCU_BASE   = BOOT_TOTAL;
    localparam int AUX0_BASE  = MCU_BASE + MCU_BYTES;
    localparam int AUX1_BASE  = AUX0_BASE + AUX0_BYTES;

    logic [AW-1:0] rbase, rsize, sect, boff, smask;

    always_comb begin
        region_ok = 1'b1;
        rbase     = '0;
        rsize     = AW'(BOOT_TOTAL);
        sect      = AW'(BOOT_SECT);
        boff      = '0;
        case (region)
            RGN_BOOT: begin
                boff = AW'({bank, addr[BANK_AW-1:0]});
            end
            RGN_MCU: begin
                rbase = AW'(MCU_BASE);
                rsize = AW'(MCU_BYTES);
                sect  = AW'(MCU_SECT);
                boff  = AW'(addr[MCU_AW-1:0]);
            end
            RGN_AUX0: begin
                rbase = AW'(AUX0_BASE);
                rsize = AW'(AUX0_BYTES);
                sect  = AW'(AUX0_BYTES);
                boff  = AW'(addr[AUX0_AW-1:0]);
            end
            RGN_AUX1: begin
                rbase = AW'(AUX1_BASE);
                rsize = AW'(AUX1_BYTES);
                sect  = AW'(AUX1_BYTES);
                boff  = AW'(addr[AUX1_AW-1:0]);
            end
            default: begin
                region_ok = 1'b0;
            end
        endcase

        smask = ~(sect - AW'(1));
        case (kind)
            JOB_SECT: begin
                base = rbase + (boff & smask);
                len  = sect;
            end
            JOB_MASS: begin
                base = rbase;
                len  = rsize;
            end
            default: begin
                base = rbase + boff;
                len  = AW'(1);
            end
        endcase
    end

    logic unused_addr_bits;
    assign unused_addr_bits = ^addr;

endmodule

// File: rtl/flash_pe_store.sv
module flash_pe_store #(
    parameter int MEM_BYTES = 1360,
    parameter int AW        = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    output logic [7:0]    old_o,
    input  logic [AW-1:0] raddr,
    input  logic          rvalid,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem [MEM_BYTES];

    assign old_o = mem[waddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem[i] <= 8'hFF;
            end
            rdata_o <= 8'h00;
        end else begin
            if (we) begin
                mem[waddr] <= wdata;
            end
            rdata_o <= rvalid ? mem[raddr] : 8'h00;
        end
    end

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
    import flash_seq_pkg::*;
#(
    parameter int BANK_BYTES = 256,
    parameter int BOOT_SECT  = 64,
    parameter int MCU_BYTES  = 256,
    parameter int MCU_SECT   = 32,
    parameter int AUX0_BYTES = 64,
    parameter int AUX1_BYTES = 16,
    parameter int PROG_CYC   = 3,
    parameter int SECT_CYC   = 5,
    parameter int MASS_CYC   = 12,
    parameter int IAW        = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            unlock,
    input  logic            reg_we,
    input  logic            reg_sel,
    input  logic [7:0]      reg_wdata,
    input  logic [IAW-1:0]  op_addr,
    input  logic [7:0]      op_data,
    input  logic [3:0]      rd_region,
    input  logic [IAW-1:0]  rd_off,
    output logic [7:0]      rd_data,
    output logic            busy,
    output logic            done,
    output logic            refused,
    output logic [7:0]      ctrl_rd,
    output logic [1:0]      bank_rd
);

    localparam int BOOT_TOTAL = NUM_BANKS * BANK_BYTES;
    localparam int MEM_BYTES  = BOOT_TOTAL + MCU_BYTES + AUX0_BYTES + AUX1_BYTES;
    localparam int AW         = $clog2(MEM_BYTES);
    localparam int WW         = $clog2(MASS_CYC + 1);
    localparam int BANK_AW    = $clog2(BANK_BYTES);

    ctrl_t                 ctrl_q;
    logic                  start_q, unlock_q;
    logic [BANK_SEL_W-1:0] bank_q;
    logic [IAW-1:0]        addr_q;
    logic [7:0]            data_q;

    seq_state_e    st;
    logic [AW-1:0] cur, remain, base_q, len_q;
    logic [WW-1:0] wcnt, wlim;
    logic          busy_q, done_q, refused_q;
    job_e          job;

    logic          map_ok, rd_ok;
    logic [AW-1:0] map_base, map_len, rd_abs, rd_len_unused;

    logic          mem_we;
    logic [7:0]    mem_wdata, mem_old;

    flash_pe_regs #(.IAW(IAW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_we   (reg_we),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .unlock   (unlock),
        .busy_i   (busy_q),
        .ctrl_q   (ctrl_q),
        .start_q  (start_q),
        .bank_q   (bank_q),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .unlock_q (unlock_q)
    );

    assign job = op_to_job(ctrl_q.op);

    flash_pe_map #(
        .BANK_BYTES(BANK_BYTES), .BOOT_SECT(BOOT_SECT),
        .MCU_BYTES(MCU_BYTES),   .MCU_SECT(MCU_SECT),
        .AUX0_BYTES(AUX0_BYTES), .AUX1_BYTES(AUX1_BYTES),
        .AW(AW), .IAW(IAW)
    ) u_op_map (
        .region   (ctrl_q.region),
        .kind     (job),
        .bank     (bank_q),
        .addr     (addr_q),
        .region_ok(map_ok),
        .base     (map_base),
        .len      (map_len)
    );

    flash_pe_map #(
        .BANK_BYTES(BANK_BYTES), .BOOT_SECT(BOOT_SECT),
        .MCU_BYTES(MCU_BYTES),   .MCU_SECT(MCU_SECT),
        .AUX0_BYTES(AUX0_BYTES), .AUX1_BYTES(AUX1_BYTES),
        .AW(AW), .IAW(IAW)
    ) u_rd_map (
        .region   (rd_region),
        .kind     (JOB_PROG),
        .bank     (rd_off[BANK_AW +: BANK_SEL_W]),
        .addr     (rd_off),
        .region_ok(rd_ok),
        .base     (rd_abs),
        .len      (rd_len_unused)
    );

    assign mem_we    = (st == SQ_PROG) || (st == SQ_ERASE);
    assign mem_wdata = (st == SQ_PROG) ? (mem_old & data_q) : 8'hFF;

    flash_pe_store #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .waddr  (cur),
        .wdata  (mem_wdata),
        .old_o  (mem_old),
        .raddr  (rd_abs),
        .rvalid (rd_ok),
        .rdata_o(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            cur       <= '0;
            remain    <= '0;
            base_q    <= '0;
            len_q     <= '0;
            wcnt      <= '0;
            wlim      <= '0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            refused_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            refused_q <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start_q) begin
                        if (map_ok && op_known(ctrl_q.op) && unlock_q) begin
                            cur    <= map_base;
                            base_q <= map_base;
                            len_q  <= map_len;
                            remain <= map_len - AW'(1);
                            busy_q <= 1'b1;
                            case (job)
                                JOB_SECT: wlim <= WW'(SECT_CYC);
                                JOB_MASS: wlim <= WW'(MASS_CYC);
                                default:  wlim <= WW'(PROG_CYC);
                            endcase
                            st <= (job == JOB_PROG) ? SQ_PROG : SQ_ERASE;
                        end else begin
                            refused_q <= 1'b1;
                        end
                    end
                end
                SQ_PROG: begin
                    wcnt <= '0;
                    st   <= SQ_WAIT;
                end
                SQ_ERASE: begin
                    if (remain == '0) begin
                        wcnt <= '0;
                        st   <= SQ_WAIT;
                    end else begin
                        cur    <= cur + AW'(1);
                        remain <= remain - AW'(1);
                    end
                end
                SQ_WAIT: begin
                    if (wcnt == wlim - WW'(1)) begin
                        st     <= SQ_IDLE;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        wcnt <= wcnt + WW'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign refused = refused_q;
    assign ctrl_rd = ctrl_q;
    assign bank_rd = bank_q;

    AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        refused |-> !busy); // R10

    AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (unlock_q && busy)); // R10

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R13

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((cur >= base_q) &&
                    ({1'b0, cur} < ({1'b0, base_q} + {1'b0, len_q})))); // R6

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_WAIT) |-> (wcnt < wlim)); // R9

    AST_PROG_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_PROG) |-> ((mem_wdata & ~mem_old) == 8'h00)); // R3

endmodule

// File: tb/tb_flash_pe_sequencer.sv
module tb_flash_pe_sequencer;

    localparam int BANK_BYTES = 256;
    localparam int BOOT_SECT  = 64;
    localparam int MCU_BYTES  = 256;
    localparam int MCU_SECT   = 32;
    localparam int AUX0_BYTES = 64;
    localparam int AUX1_BYTES = 16;
    localparam int PROG_CYC   = 3;
    localparam int SECT_CYC   = 5;
    localparam int MASS_CYC   = 12;
    localparam int BOOT_TOTAL = 4 * BANK_BYTES;
    localparam int MEM_BYTES  = BOOT_TOTAL + MCU_BYTES + AUX0_BYTES + AUX1_BYTES;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unlock = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] op_addr = '0;
    logic [7:0]  op_data = '0;
    logic [3:0]  rd_region = '0;
    logic [15:0] rd_off = '0;
    logic [7:0]  rd_data;
    logic        busy, done, refused;
    logic [7:0]  ctrl_rd;
    logic [1:0]  bank_rd;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] model [MEM_BYTES];
    int cur_bank = 0;

    always #10 clk = ~clk;

    flash_pe_sequencer #(
        .BANK_BYTES(BANK_BYTES), .BOOT_SECT(BOOT_SECT),
        .MCU_BYTES(MCU_BYTES),   .MCU_SECT(MCU_SECT),
        .AUX0_BYTES(AUX0_BYTES), .AUX1_BYTES(AUX1_BYTES),
        .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .MASS_CYC(MASS_CYC),
        .IAW(16)
    ) dut (
        .clk(clk), .rst(rst), .unlock(unlock),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .op_addr(op_addr), .op_data(op_data),
        .rd_region(rd_region), .rd_off(rd_off), .rd_data(rd_data),
        .busy(busy), .done(done), .refused(refused),
        .ctrl_rd(ctrl_rd), .bank_rd(bank_rd)
    );

    function automatic int rbase(input int r);
        case (r)
            0: return 0;
            1: return BOOT_TOTAL;
            2: return BOOT_TOTAL + MCU_BYTES;
            default: return BOOT_TOTAL + MCU_BYTES + AUX0_BYTES;
        endcase
    endfunction

    function automatic int rsize(input int r);
        case (r)
            0: return BOOT_TOTAL;
            1: return MCU_BYTES;
            2: return AUX0_BYTES;
            default: return AUX1_BYTES;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] val);
        reg_we    = 1'b1;
        reg_sel   = sel;
        reg_wdata = val;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic scan(input string tag);
        int errs = 0;
        int fa = 0, fe = 0;
        for (int r = 0; r < 4; r++) begin
            for (int o = 0; o < rsize(r); o++) begin
                rd_region = 4'(r);
                rd_off    = 16'(o);
                @(negedge clk);
                if (rd_data !== model[rbase(r) + o]) begin
                    if (errs == 0) begin
                        fa = rd_data;
                        fe = model[rbase(r) + o];
                    end
                    errs++;
                end
            end
        end
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s: store scan %0d bytes wrong, first actual=%0h expected=%0h",
                     tag, errs, fa, fe);
        end
    endtask

    // Model update and expected busy length, computed from R3..R9
    task automatic model_apply(input int r, input int op, input int addr,
                               input int data, output int cycles);
        int boff, start, len, lim;
        boff = (r == 0) ? (cur_bank * BANK_BYTES + (addr % BANK_BYTES))
                        : (addr % rsize(r));
        if (op == 1) begin
            model[rbase(r) + boff] = model[rbase(r) + boff] & data[7:0];
            cycles = 1 + PROG_CYC;
            return;
        end
        if (op == 2) begin
            lim = SECT_CYC;
            if (r == 0)      begin len = BOOT_SECT; start = boff - (boff % BOOT_SECT); end
            else if (r == 1) begin len = MCU_SECT;  start = boff - (boff % MCU_SECT);  end
            else             begin len = rsize(r);  start = 0; end
        end else begin
            lim = MASS_CYC; len = rsize(r); start = 0;
        end
        for (int i = 0; i < len; i++) model[rbase(r) + start + i] = 8'hFF;
        cycles = len + lim;
    endtask

    task automatic run_op(input string tag, input int r, input int op,
                          input int addr, input int data);
        int exp_cyc, cnt;
        bit seen;
        op_addr = 16'(addr);
        op_data = 8'(data);
        wr_reg(1'b0, 8'((op << 5) | 16 | r));
        model_apply(r, op, addr, data, exp_cyc);
        cnt = 0; seen = 0;
        for (int g = 0; g < 4000; g++) begin
            if (busy) begin cnt++; seen = 1; end
            else if (seen) break;
            @(negedge clk);
        end
        check({tag, " R9 busy length"}, cnt, exp_cyc);
        check({tag, " R13 done at busy fall"}, done, 1);
        @(negedge clk);
        check({tag, " R13 done one cycle"}, done, 0);
    endtask

    task automatic run_refused(input string tag, input logic [7:0] word);
        wr_reg(1'b0, word);
        @(negedge clk);
        check({tag, " refused pulse"}, refused, 1);
        check({tag, " busy stays low"}, busy, 0);
        @(negedge clk);
        check({tag, " refused one cycle"}, refused, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 refused", refused, 0);
        check("R1 ctrl", ctrl_rd, 0);
        check("R1 bank", bank_rd, 0);
        scan("R1");

        // R2 readback without start, then start clears itself; locked -> R10
        wr_reg(1'b0, 8'h21);
        check("R2 readback no start", ctrl_rd, 8'h21);
        @(negedge clk);
        check("R2 no start no busy", busy, 0);
        op_addr = 16'h0005; op_data = 8'h00;
        wr_reg(1'b0, 8'h31);
        check("R2 start visible", ctrl_rd, 8'h31);
        @(negedge clk);
        check("R2 start self clears", ctrl_rd, 8'h21);
        check("R10 refused when locked", refused, 1);
        check("R10 busy low when locked", busy, 0);
        scan("R10");

        unlock = 1'b1;

        // R4 bank register width
        wr_reg(1'b1, 8'h07);
        check("R4 bank keeps low bits", bank_rd, 3);

        // R3/R4 programming sweep across banks with out-of-bank addresses
        for (int b = 0; b < 4; b++) begin
            wr_reg(1'b1, 8'(b));
            cur_bank = b;
            check("R4 bank write", bank_rd, b);
            run_op("R4 prog", 0, 1, 16'h0105 + b * 37, 8'hA5 ^ (b * 17));
            run_op("R3 prog and", 0, 1, 16'h0105 + b * 37, 8'h3C);
        end
        scan("R3 R4");

        // R5 wrapping in other regions
        run_op("R5 mcu", 1, 1, 16'h1234, 8'h5A);
        run_op("R5 mcu again", 1, 1, 16'h0034, 8'hF0);
        run_op("R5 aux0", 2, 1, 16'h0047, 8'h81);
        run_op("R5 aux1", 3, 1, 16'h001F, 8'h42);
        scan("R5");

        // R6 sector erase with bytes at sector edges and just outside
        wr_reg(1'b1, 8'h02);
        cur_bank = 2;
        run_op("R6 setup", 0, 1, 16'h00C0, 8'h00);
        run_op("R6 setup", 0, 1, 16'h00FF, 8'h11);
        run_op("R6 setup", 0, 1, 16'h00BF, 8'h22);
        run_op("R6 setup", 0, 1, 16'h0100, 8'h33);
        run_op("R6 boot sect", 0, 2, 16'h01C5, 0);
        scan("R6 boot");
        run_op("R6 setup", 1, 1, 16'h001F, 8'h0F);
        run_op("R6 setup", 1, 1, 16'h0040, 8'h0E);
        run_op("R6 mcu sect", 1, 2, 16'h0030, 0);
        scan("R6 mcu");

        // R7 auxiliary regions erase whole
        run_op("R7 setup", 2, 1, 16'h0000, 8'h00);
        run_op("R7 setup", 3, 1, 16'h0000, 8'h00);
        run_op("R7 aux0 sect", 2, 2, 16'h0003, 0);
        run_op("R7 aux1 mass", 3, 4, 16'h0000, 0);
        scan("R7");

        // R11 unknown region / operation
        run_refused("R11 region", 8'h35);
        run_refused("R11 op", 8'h70);
        scan("R11");

        // R12 writes while busy are dropped; R8 mcu mass erase
        run_op("R12 setup", 1, 1, 16'h0010, 8'h00);
        op_addr = 16'h0000;
        wr_reg(1'b0, 8'h91);
        begin
            int dummy;
            model_apply(1, 4, 0, 0, dummy);
        end
        @(negedge clk);
        @(negedge clk);
        wr_reg(1'b0, 8'h30);
        wr_reg(1'b1, 8'h01);
        for (int g = 0; g < 4000; g++) begin
            if (!busy) break;
            @(negedge clk);
        end
        check("R12 ctrl kept", ctrl_rd, 8'h81);
        check("R12 bank kept", bank_rd, 2);
        @(negedge clk);
        check("R12 no second op", busy, 0);
        scan("R8 R12");

        // R8 boot mass erase across all banks
        run_op("R8 boot mass", 0, 4, 16'h0000, 0);
        scan("R8");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule